// File: doc/BRIEF.md
# Region-Context Configuration Store

This block is the local configuration store of a reconfigurable functional unit that supports virtual opcodes. Storage is split into `REGIONS` region contexts. Each region context holds `SLOTS` instruction configurations of `CFG_W` bits, so the total storage is `REGIONS * SLOTS * CFG_W` bits. Exactly one region context is active at any time. A lookup uses a natural opcode, and that opcode picks a configuration slot inside the active region. The same opcode therefore selects different configurations in different code regions.

Software loads configurations through a write port that carries a region index, a slot index and a data word. A region-activation command makes another region current. The switch costs one stall cycle, and no memory reload takes place. Choosing a slot within the active region adds no cycles. A lookup accepted in one cycle returns its result, registered, in the next cycle. The processing-element array and the bitstream source are outside this block.

Top module: `rcs_ctx_store`

## Requirements
- R1: After reset, region 0 is active, `busy` and `cfg_valid` are 0, and every slot of every region reads as invalid until it is written.
- R2: A lookup (`lk_valid`=1 while `busy`=0) produces `cfg_valid`=1 on the next cycle. For a written slot, `cfg_invalid`=0 and `cfg_data` is the configuration stored at [active region][`lk_opcode`].
- R3: A write sets the contents and the valid mark of [`wr_region`][`wr_slot`]. Any lookup in a later cycle sees the new data, including lookups into the active region. A lookup in the same cycle as the write returns the previous contents.
- R4: The same opcode returns the configuration of whichever region is active, so equal opcodes in different regions give different results.
- R5: An accepted activation (`act_en`=1, `act_region` < `REGIONS`, `busy`=0) drives `busy` to 1 for exactly the next cycle. A lookup presented while `busy`=1 is not accepted and produces no result (`cfg_valid`=0 one cycle later).
- R6: A lookup in the same cycle as an accepted activation uses the old region. Lookups from the cycle after `busy` ends use the new region.
- R7: A lookup with `lk_opcode` >= `SLOTS` returns `cfg_valid`=1, `cfg_invalid`=1 and `cfg_data` all zeros.
- R8: A lookup of a slot that has never been written returns `cfg_invalid`=1 and `cfg_data` all zeros.
- R9: A write with `wr_region` >= `REGIONS` or `wr_slot` >= `SLOTS` changes no stored configuration.
- R10: An activation with `act_region` >= `REGIONS` is ignored. `busy` stays 0 and the active region does not change.
- R11: An activation presented while `busy`=1 is ignored. The region chosen by the earlier activation stays active.
- R12: Lookups presented in consecutive cycles with `busy`=0 each produce a result on consecutive cycles, with no extra cycle to select a slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_region | input | 2 | Region index of the write |
| wr_slot | input | 3 | Slot index of the write |
| wr_data | input | 136 | Configuration word to store |
| act_en | input | 1 | Region activation command |
| act_region | input | 2 | Region to make active |
| lk_valid | input | 1 | Lookup request |
| lk_opcode | input | 4 | Natural opcode of the lookup |
| busy | output | 1 | High for the single switch cycle; lookups stall |
| cfg_valid | output | 1 | A lookup result is present |
| cfg_invalid | output | 1 | The result has no configuration (opcode out of range or slot empty) |
| cfg_data | output | 136 | Configuration word, zero when invalid |

## Verification
The bench looks up the same opcodes before and after region switches. A store that ignored the region level would return one region's data everywhere. It issues a lookup alongside an activation, another during the busy cycle, and a second activation during that busy cycle. A store that switched a cycle early, let stalled lookups through, or accepted the second command would return the wrong region or produce an extra result. It also writes into the active region while looking up the same slot, to check that the old and new data appear in the right cycles. Finally it probes opcodes past the slot count, empty slots, out-of-range write regions and an out-of-range activation. A design with loose range checks would return stale data, corrupt a real slot, or raise busy.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
   typedef enum logic {
      CTX_STEADY = 1'b0,
      CTX_SWITCH = 1'b1
   } ctx_state_e;

   function automatic int idx_bits(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/rcs_region_ctl.sv
module rcs_region_ctl
   import rcs_pkg::*;
#(
   parameter int REGIONS = 3,
   parameter int RW      = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          act_en,
   input  logic [RW-1:0] act_region,
   output logic [RW-1:0] cur_region,
   output logic          busy
);
   localparam logic [RW:0] NREG = (RW+1)'(REGIONS);

   ctx_state_e state_q;
   logic       req_ok;

   assign req_ok = act_en && ({1'b0, act_region} < NREG);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= CTX_STEADY;
         cur_region <= '0;
      end else begin
         case (state_q)
            CTX_STEADY: begin
               if (req_ok) begin
                  cur_region <= act_region;
                  state_q    <= CTX_SWITCH;
               end
            end
            default: state_q <= CTX_STEADY;
         endcase
      end
   end

   assign busy = (state_q == CTX_SWITCH);
endmodule

// File: rtl/rcs_slot_bank.sv
module rcs_slot_bank #(
   parameter int SLOTS = 6,
   parameter int CFG_W = 136,
   parameter int SW    = 3,
   parameter int OPC_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [SW-1:0]    wr_slot,
   input  logic [CFG_W-1:0] wr_data,
   input  logic [OPC_W-1:0] rd_opc,
   output logic             rd_hit,
   output logic [CFG_W-1:0] rd_data
);
   localparam bit WR_PARTIAL = (SLOTS < (1 << SW));
   localparam bit RD_PARTIAL = (SLOTS < (1 << OPC_W));

   logic [CFG_W-1:0] mem [SLOTS];
   logic [SLOTS-1:0] vld;
   logic             wr_ok;
   logic             rd_in;
   logic [SW-1:0]    rd_idx;

   generate
      if (WR_PARTIAL) begin : g_wr_chk
         assign wr_ok = (wr_slot <= SW'(SLOTS-1));
      end else begin : g_wr_all
         assign wr_ok = 1'b1;
      end
      if (RD_PARTIAL) begin : g_rd_chk
         assign rd_in = (rd_opc <= OPC_W'(SLOTS-1));
      end else begin : g_rd_all
         assign rd_in = 1'b1;
      end
   endgenerate

   assign rd_idx = rd_opc[SW-1:0];

   always_ff @(posedge clk) begin
      if (wr_en && wr_ok) mem[wr_slot] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)             vld          <= '0;
      else if (wr_en && wr_ok) vld[wr_slot] <= 1'b1;
   end

   always_comb begin
      rd_hit  = rd_in && vld[rd_idx];
      rd_data = rd_hit ? mem[rd_idx] : '0;
   end
endmodule

// File: rtl/rcs_ctx_store.sv
module rcs_ctx_store
   import rcs_pkg::*;
#(
   parameter int REGIONS = 3,
   parameter int SLOTS   = 6,
   parameter int CFG_W   = 136,
   parameter int OPC_W   = 4,
   parameter int RW      = idx_bits(REGIONS),
   parameter int SW      = idx_bits(SLOTS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [RW-1:0]    wr_region,
   input  logic [SW-1:0]    wr_slot,
   input  logic [CFG_W-1:0] wr_data,
   input  logic             act_en,
   input  logic [RW-1:0]    act_region,
   input  logic             lk_valid,
   input  logic [OPC_W-1:0] lk_opcode,
   output logic             busy,
   output logic             cfg_valid,
   output logic             cfg_invalid,
   output logic [CFG_W-1:0] cfg_data
);
   generate
      if (REGIONS < 1) begin : g_bad_regions
         $error("REGIONS must be at least 1");
      end
      if (SLOTS < 1) begin : g_bad_slots
         $error("SLOTS must be at least 1");
      end
      if (CFG_W < 1) begin : g_bad_width
         $error("CFG_W must be at least 1");
      end
      if (OPC_W < SW) begin : g_bad_opc
         $error("OPC_W must cover every slot index");
      end
   endgenerate

   logic [RW-1:0]    cur_region;
   logic             bank_hit  [REGIONS];
   logic [CFG_W-1:0] bank_data [REGIONS];
   logic             sel_hit;
   logic [CFG_W-1:0] sel_data;
   logic             accept;

   rcs_region_ctl #(.REGIONS(REGIONS), .RW(RW)) u_ctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .act_en     (act_en),
      .act_region (act_region),
      .cur_region (cur_region),
      .busy       (busy)
   );

   generate
      for (genvar r = 0; r < REGIONS; r++) begin : g_bank
         rcs_slot_bank #(.SLOTS(SLOTS), .CFG_W(CFG_W), .SW(SW), .OPC_W(OPC_W)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en && (wr_region == RW'(r))),
            .wr_slot (wr_slot),
            .wr_data (wr_data),
            .rd_opc  (lk_opcode),
            .rd_hit  (bank_hit[r]),
            .rd_data (bank_data[r])
         );
      end
   endgenerate

   always_comb begin
      sel_hit  = 1'b0;
      sel_data = '0;
      for (int r = 0; r < REGIONS; r++) begin
         if (cur_region == RW'(r)) begin
            sel_hit  = bank_hit[r];
            sel_data = bank_data[r];
         end
      end
   end

   assign accept = lk_valid && !busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_valid   <= 1'b0;
         cfg_invalid <= 1'b0;
         cfg_data    <= '0;
      end else begin
         cfg_valid   <= accept;
         cfg_invalid <= accept && !sel_hit;
         cfg_data    <= (accept && sel_hit) ? sel_data : '0;
      end
   end
endmodule

// File: rtl/rcs_ctx_store_chk.sv
module rcs_ctx_store_chk #(
   parameter int REGIONS = 3,
   parameter int SLOTS   = 6,
   parameter int CFG_W   = 136,
   parameter int OPC_W   = 4,
   parameter int RW      = 2,
   parameter int SW      = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [RW-1:0]    wr_region,
   input logic [SW-1:0]    wr_slot,
   input logic [CFG_W-1:0] wr_data,
   input logic             act_en,
   input logic [RW-1:0]    act_region,
   input logic             lk_valid,
   input logic [OPC_W-1:0] lk_opcode,
   input logic             busy,
   input logic             cfg_valid,
   input logic             cfg_invalid,
   input logic [CFG_W-1:0] cfg_data
);
   localparam logic [RW:0]    NREG = (RW+1)'(REGIONS);
   localparam logic [OPC_W:0] NSLT = (OPC_W+1)'(SLOTS);

   logic act_ok;
   assign act_ok = act_en && ({1'b0, act_region} < NREG);

   a_r5_busy_on_act: assert property (@(posedge clk) disable iff (!rst_n)
      (act_ok && !busy) |=> busy);

   a_r11_busy_single: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !busy);

   a_r10_no_spurious_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !act_ok) |=> !busy);

   a_r2_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && !busy) |=> cfg_valid);

   a_r5_stall_no_result: assert property (@(posedge clk) disable iff (!rst_n)
      (busy || !lk_valid) |=> !cfg_valid);

   a_r7_oob_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && !busy && ({1'b0, lk_opcode} >= NSLT)) |=> (cfg_invalid && cfg_data == '0));

   a_r8_invalid_clean: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_invalid |-> (cfg_valid && cfg_data == '0));
endmodule

bind rcs_ctx_store rcs_ctx_store_chk #(
   .REGIONS(REGIONS), .SLOTS(SLOTS), .CFG_W(CFG_W),
   .OPC_W(OPC_W), .RW(RW), .SW(SW)
) u_chk (.*);

// File: tb/rcs_ctx_store_test.sv
`timescale 1ns/1ps
module rcs_ctx_store_test;
   localparam int REGIONS = 3;
   localparam int SLOTS   = 6;
   localparam int CFG_W   = 136;
   localparam int OPC_W   = 4;
   localparam int RW      = 2;
   localparam int SW      = 3;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             wr_en = 1'b0;
   logic [RW-1:0]    wr_region = '0;
   logic [SW-1:0]    wr_slot = '0;
   logic [CFG_W-1:0] wr_data = '0;
   logic             act_en = 1'b0;
   logic [RW-1:0]    act_region = '0;
   logic             lk_valid = 1'b0;
   logic [OPC_W-1:0] lk_opcode = '0;
   logic             busy, cfg_valid, cfg_invalid;
   logic [CFG_W-1:0] cfg_data;

   rcs_ctx_store uut (.*);

   always #2 clk = ~clk;

   typedef struct {
      int               due;
      bit               inv;
      logic [CFG_W-1:0] data;
      string            tag;
   } exp_t;

   exp_t             q[$];
   int               cyc = 0;
   int               n_chk = 0;
   int               n_bad = 0;
   bit               started = 1'b0;
   bit               done = 1'b0;
   logic [CFG_W-1:0] m_mem [REGIONS][SLOTS];
   bit               m_vld [REGIONS][SLOTS];
   int               m_reg = 0;
   bit               m_busy = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [CFG_W-1:0] pat(input int r, input int s, input int salt);
      logic [CFG_W-1:0] v;
      for (int i = 0; i < CFG_W/8; i++) v[i*8 +: 8] = 8'(salt*31 + r*67 + s*13 + i*7 + 1);
      return v;
   endfunction

   task automatic step(input bit we, input int wr, input int ws, input logic [CFG_W-1:0] wd,
                       input bit ae, input int ar, input bit lv, input int lo, input string tag);
      exp_t e;
      bit   nb;
      wr_en = we; wr_region = RW'(wr); wr_slot = SW'(ws); wr_data = wd;
      act_en = ae; act_region = RW'(ar); lk_valid = lv; lk_opcode = OPC_W'(lo);
      if (lv && !m_busy) begin
         e.due = cyc + 1;
         e.tag = tag;
         if (lo >= SLOTS || !m_vld[m_reg][lo]) begin
            e.inv = 1'b1; e.data = '0;
         end else begin
            e.inv = 1'b0; e.data = m_mem[m_reg][lo];
         end
         q.push_back(e);
      end
      if (we && wr < REGIONS && ws < SLOTS) begin
         m_mem[wr][ws] = wd; m_vld[wr][ws] = 1'b1;
      end
      nb = ae && ar < REGIONS && !m_busy;
      if (nb) m_reg = ar;
      m_busy = nb;
      @(negedge clk);
      n_chk++;
      if (busy !== m_busy) begin
         n_bad++;
         $display("FAIL %s/R5 busy: actual %0b expected %0b", tag, busy, m_busy);
      end
   endtask

   task automatic wr_cfg(input int r, input int s, input int salt, input string tag);
      step(1, r, s, pat(r, s, salt), 0, 0, 0, 0, tag);
   endtask

   task automatic look(input int o, input string tag);
      step(0, 0, 0, '0, 0, 0, 1, o, tag);
   endtask

   always @(negedge clk) begin
      if (started && !done) begin
         n_chk++;
         if (q.size() > 0 && q[0].due == cyc) begin
            exp_t e;
            e = q.pop_front();
            if (cfg_valid !== 1'b1 || cfg_invalid !== e.inv || cfg_data !== e.data) begin
               n_bad++;
               $display("FAIL %s: actual v=%0b inv=%0b data=%h expected v=1 inv=%0b data=%h",
                        e.tag, cfg_valid, cfg_invalid, cfg_data, e.inv, e.data);
            end
         end else if (cfg_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R5 unexpected result: actual cfg_valid=%0b expected 0", cfg_valid);
         end
      end
   end

   initial begin
      repeat (40000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      for (int r = 0; r < REGIONS; r++)
         for (int s = 0; s < SLOTS; s++) begin m_mem[r][s] = '0; m_vld[r][s] = 1'b0; end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      n_chk++;
      if (busy !== 1'b0 || cfg_valid !== 1'b0) begin
         n_bad++;
         $display("FAIL R1 reset: actual busy=%0b v=%0b expected 0 0", busy, cfg_valid);
      end
      started = 1'b1;
      // R1 / R8: everything empty after reset
      for (int o = 0; o < SLOTS; o++) look(o, "R1_empty");
      // load all regions (R9 write to region 3 dropped)
      for (int s = 0; s < SLOTS; s++) wr_cfg(0, s, 1, "R3_load");
      for (int s = 0; s < SLOTS; s++) wr_cfg(1, s, 2, "R3_load");
      for (int s = 0; s < 3; s++) wr_cfg(2, s, 3, "R3_load");
      wr_cfg(3, 0, 9, "R9_bad_region");
      wr_cfg(3, 4, 9, "R9_bad_region");
      // R2 / R7 / R12: back-to-back lookups in region 0, including out-of-range opcodes
      for (int o = 0; o < 16; o++) look(o, (o >= SLOTS) ? "R7_oob" : "R12_r2_stream");
      // R3: write into the active region while looking up the same slot
      step(1, 0, 2, pat(0, 2, 5), 0, 0, 1, 2, "R3_old_same_cycle");
      look(2, "R3_new_visible");
      // R6: lookup beside activation uses old region
      step(0, 0, 0, '0, 1, 1, 1, 1, "R6_old_region");
      // R5 / R11: stalled lookup and ignored second activation
      step(0, 0, 0, '0, 1, 2, 1, 2, "R11_act_while_busy");
      for (int o = 0; o < SLOTS; o++) look(o, "R4_r6_region1");
      // R10: activation past last region ignored
      step(0, 0, 0, '0, 1, 3, 1, 0, "R10_bad_act");
      look(3, "R10_still_region1");
      // region 2: partially written (R8)
      step(0, 0, 0, '0, 1, 2, 0, 0, "R5_switch");
      step(0, 0, 0, '0, 0, 0, 1, 0, "R5_stall");
      for (int o = 0; o < 7; o++) look(o, (o < 3) ? "R4_region2" : "R8_unwritten");
      // R9: region 0 slots unchanged by dropped writes
      step(0, 0, 0, '0, 1, 0, 0, 0, "R5_switch");
      look(0, "R9_r4_region0");
      look(4, "R9_region0");
      look(2, "R3_region0");
      repeat (3) step(0, 0, 0, '0, 0, 0, 0, 0, "idle");
      n_chk++;
      if (q.size() != 0) begin
         n_bad++;
         $display("FAIL R2 drain: actual %0d pending expected 0", q.size());
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule